// File: doc/BRIEF.md
# Hierarchical Crosswise Array Multiplier

This block is a purely combinational unsigned multiplier. Two operands of `WIDTH` bits go in, and their full `2*WIDTH`-bit product comes out. No clock is involved. The design never uses the `*` operator and is not a shift-and-add array or a compression tree. It is built by recursion instead.

The leaf is a 2x2-bit cell. It forms every bit product at once and resolves them column by column. Each column sum absorbs the carry from the column to its right. The digit stays in that column and the rest carries onward.

A node of width 2N splits each operand into a high half and a low half. It forms four NxN sub-products: low-low, high-low, low-high and high-high. It then adds them as follows:

- the two cross terms, shifted left by N;
- the high-high term, shifted left by 2N;
- both of these onto the low-low term.

`WIDTH` may be 2, 4, 8, 16 or 32. Any other value stops elaboration.

Top module: `cwm_mult`

## Requirements
- R1: For WIDTH=32, `product` equals the exact unsigned 64-bit product of `op_a` and `op_b` for any operand pair.
- R2: For WIDTH=2, all 16 operand pairs give product bits {p3,p2,p1,p0} that match the 2x2 rule. p0 is a0&b0. p1 is the XOR of a1&b0 and a0&b1, and their AND is the column carry. p2 is a1&b1 XOR that carry. p3 is their AND, so p3 is 1 only when both operands are 3.
- R3: When either operand is zero, the product is zero.
- R4: When both operands are all ones, the product equals 2^(2W) - 2^(W+1) + 1.
- R5: For WIDTH=4 and WIDTH=8, every one of the operand pairs gives the exact unsigned product.
- R6: When one operand is 2^k, the product equals the other operand shifted left by k bits.
- R7: The product follows an input change within the same time step, with no clock edge in between.
- R8: Take `op_a` with only its upper half nonzero and `op_b` with only its lower half nonzero. The product then equals (upper half of `op_a` times `op_b`) shifted left by WIDTH/2. This is the placement of a cross term.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Unsigned multiplicand |
| op_b | input | WIDTH | Unsigned multiplier |
| product | output | 2*WIDTH | Unsigned full-width product |

## Verification
The hardest cases to reach are carries that cross a quadrant boundary. One is a cross-term sum that overflows into the high-high region. Another is a 2x2 middle-column carry that must ripple through several levels of the recursion. Random 32-bit operands seldom line these up.

The stimulus therefore covers the 4-bit and 8-bit instances exhaustively, and with them every carry pattern of one and two levels of recursion. At 32 bits it adds the following:

- all-ones operands, which saturate every column;
- single-bit operands, which expose misplaced shifts;
- operands with only the upper half or only the lower half nonzero, which isolate one cross term.

// File: rtl/cwm_pkg.sv
package cwm_pkg;

  // One column of the crosswise rule: two bit products plus an incoming
  // carry. Returns {carry_out, digit}.
  function automatic logic [1:0] col_resolve(input logic x, input logic y,
                                             input logic cin);
    logic [1:0] s;
    s = {1'b0, x} + {1'b0, y} + {1'b0, cin};
    return s;
  endfunction

  // True when w is a supported power of two.
  function automatic bit width_ok(input int w);
    return (w == 2) || (w == 4) || (w == 8) || (w == 16) || (w == 32);
  endfunction

endpackage

// File: rtl/cwm_cell2.sv
module cwm_cell2
  import cwm_pkg::*;
(
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic       bp00, bp10, bp01, bp11;
  logic [1:0] mid_col;
  logic [1:0] top_col;
  logic       mid_carry;

  always_comb begin
    bp00 = a[0] & b[0];
    bp10 = a[1] & b[0];
    bp01 = a[0] & b[1];
    bp11 = a[1] & b[1];
    mid_col   = col_resolve(bp10, bp01, 1'b0);
    mid_carry = mid_col[1];
    top_col   = col_resolve(bp11, mid_carry, 1'b0);
    p = {top_col, mid_col[0], bp00};
  end

  always_comb begin
    // R2: the top bit is reachable only from 3 x 3
    p_top_bit_r2: assert (!p[3] || (a == 2'b11 && b == 2'b11))
      else $error("cell top bit set for a=%0d b=%0d", a, b);
    // R3: a zero operand leaves every cell output low
    p_zero_cell_r3: assert (!(a == 2'b00 || b == 2'b00) || p == 4'b0000)
      else $error("cell nonzero with zero operand");
  end
endmodule

// File: rtl/cwm_combine.sv
module cwm_combine #(
  parameter int N = 2
) (
  input  logic [2*N-1:0] ll,
  input  logic [2*N-1:0] hl,
  input  logic [2*N-1:0] lh,
  input  logic [2*N-1:0] hh,
  output logic [4*N-1:0] res
);
  localparam int CW = 2*N + 1;

  logic [CW-1:0]  cross_sum;
  logic [4*N-1:0] outer;
  logic [4*N-1:0] cross_placed;

  always_comb begin
    cross_sum    = {1'b0, hl} + {1'b0, lh};
    outer        = {hh, ll};
    cross_placed = '0;
    cross_placed[N +: CW] = cross_sum;
    res = outer + cross_placed;
  end

  always_comb begin
    // R8: with no cross or high terms, the low sub-product passes alone
    p_low_only_r8: assert (!(hh == '0 && hl == '0 && lh == '0) ||
                           res == {{(2*N){1'b0}}, ll})
      else $error("combine altered a lone low term");
  end
endmodule

// File: rtl/cwm_node.sv
module cwm_node #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int H = W / 2;

  generate
    if (W == 2) begin : g_leaf
      cwm_cell2 u_cell (.a(a), .b(b), .p(p));
    end else begin : g_split
      logic [2*H-1:0] q_ll, q_hl, q_lh, q_hh;

      cwm_node #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(q_ll));
      cwm_node #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(q_hl));
      cwm_node #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(q_lh));
      cwm_node #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(q_hh));

      cwm_combine #(.N(H)) u_comb (
        .ll (q_ll),
        .hl (q_hl),
        .lh (q_lh),
        .hh (q_hh),
        .res(p)
      );
    end
  endgenerate
endmodule

// File: rtl/cwm_mult.sv
module cwm_mult
  import cwm_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;

  generate
    if (!width_ok(WIDTH)) begin : g_bad_width
      $error("cwm_mult: WIDTH must be 2, 4, 8, 16 or 32");
    end
  endgenerate

  logic [PW-1:0] tree_out;

  cwm_node #(.W(WIDTH)) u_tree (.a(op_a), .b(op_b), .p(tree_out));

  assign product = tree_out;

  always_comb begin
    // R3: a zero operand yields a zero product
    p_zero_r3: assert (!(op_a == '0 || op_b == '0) || product == '0)
      else $error("nonzero product with zero operand");
    // R6: multiplying by one returns the other operand unchanged
    p_unit_r6: assert (!(op_a == {{(WIDTH-1){1'b0}}, 1'b1}) ||
                       product == {{WIDTH{1'b0}}, op_b})
      else $error("unit multiplier altered operand");
  end
endmodule

// File: tb/cwm_mult_tb.sv
module cwm_mult_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] a32 = '0, b32 = '0;
  logic [63:0] p32;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] p8;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [7:0]  p4;
  logic [1:0]  a2 = '0, b2 = '0;
  logic [3:0]  p2;

  cwm_mult #(.WIDTH(32)) u_dut  (.op_a(a32), .op_b(b32), .product(p32));
  cwm_mult #(.WIDTH(8))  u_dut8 (.op_a(a8),  .op_b(b8),  .product(p8));
  cwm_mult #(.WIDTH(4))  u_dut4 (.op_a(a4),  .op_b(b4),  .product(p4));
  cwm_mult #(.WIDTH(2))  u_dut2 (.op_a(a2),  .op_b(b2),  .product(p2));

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  logic [63:0] exp_q[$];

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mul(input longint unsigned x,
                                          input longint unsigned y);
    return 64'(x * y);
  endfunction

  // Drive one 32-bit vector on a posedge, queue its expectation,
  // check at the next negedge.
  task automatic run32(input string req, input logic [31:0] x,
                       input logic [31:0] y);
    @(posedge clk);
    a32 = x; b32 = y;
    exp_q.push_back(ref_mul(longint'(x), longint'(y)));
    @(negedge clk);
    chk(req, p32, exp_q.pop_front());
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: zero operands, zero products (R3)
    chk("R3 reset p32", p32, 64'd0);
    chk("R3 reset p8", {48'd0, p8}, 64'd0);

    // R2: 2x2 cell, all pairs, plus top-bit rule
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        @(posedge clk);
        a2 = 2'(i); b2 = 2'(j);
        @(negedge clk);
        chk("R2 cell product", {60'd0, p2}, 64'(i * j));
        chk("R2 cell top bit", {63'd0, p2[3]}, {63'd0, (i == 3 && j == 3)});
      end

    // R5: exhaustive 4-bit and 8-bit
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) begin
        @(posedge clk);
        a4 = 4'(i); b4 = 4'(j);
        @(negedge clk);
        chk("R5 4x4", {56'd0, p4}, 64'(i * j));
      end
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++) begin
        @(posedge clk);
        a8 = 8'(i); b8 = 8'(j);
        @(negedge clk);
        chk("R5 8x8", {48'd0, p8}, 64'(i * j));
      end

    // R3: zero on either side at 32 bits
    run32("R3 zero a", 32'd0, 32'hDEADBEEF);
    run32("R3 zero b", 32'hFFFFFFFF, 32'd0);

    // R4: all ones at every width
    run32("R4 ones 32", 32'hFFFFFFFF, 32'hFFFFFFFF);
    chk("R4 ones 32 formula", p32, 64'hFFFFFFFE00000001);
    @(posedge clk); a8 = 8'hFF; b8 = 8'hFF; a4 = 4'hF; b4 = 4'hF;
    @(negedge clk);
    chk("R4 ones 8", {48'd0, p8}, 64'd65025);
    chk("R4 ones 4", {56'd0, p4}, 64'd225);

    // R6: powers of two
    for (int k = 0; k < 32; k++) begin
      run32("R6 pow2", 32'd1 << k, 32'h9ABCDEF1);
      chk("R6 shift", p32, 64'h9ABCDEF1 << k);
    end

    // R8: isolated cross term
    run32("R8 cross", 32'hABCD0000, 32'h00001234);
    chk("R8 cross placement", p32, (64'hABCD * 64'h1234) << 16);
    run32("R8 cross max", 32'hFFFF0000, 32'h0000FFFF);

    // R7: change inputs between edges, product settles with no edge
    @(negedge clk);
    a32 = 32'd123456; b32 = 32'd654321;
    #1;
    chk("R7 same step", p32, 64'd123456 * 64'd654321);

    // R1: random operands
    for (int n = 0; n < 3000; n++)
      run32("R1 random", $urandom, $urandom);
    run32("R1 top bits", 32'h80000000, 32'h80000001);

    finish_run();
  end
endmodule